// File: doc/BRIEF.md
# ADC Window Watchdog Comparator

This block sits beside a converter's result path and checks each converted sample against a programmable window. The window is bounded by an upper and a lower 12-bit limit. When a qualified sample lies strictly outside the window, a sticky violation flag is set. The flag stays set until software clears it by writing one to a clear strobe. A separate interrupt enable decides whether the flag reaches the interrupt line.

The block watches either every channel or only one chosen channel. It compares the raw converted value, before any result alignment, so how results are later placed in a data word cannot change the outcome. The limits come straight from configuration inputs, so a new limit applies to the very next sample that is presented.

Top module: `adc_window_watch`

## Requirements
- R1: After a synchronous active-low reset, `viol_flag` and `viol_irq` are 0.
- R2: A qualified sample with `smp_data` greater than `lim_high` sets `viol_flag` on the clock edge that captures the sample, so the flag is visible one cycle after `smp_valid`.
- R3: A qualified sample with `smp_data` less than `lim_low` sets `viol_flag` in the same way.
- R4: A sample equal to `lim_high` or equal to `lim_low`, or lying between them, does not set `viol_flag`.
- R5: With `wd_enable` low, no sample sets `viol_flag`.
- R6: With `wd_enable` high and `wd_single` low, a sample on any channel is checked.
- R7: With `wd_enable` and `wd_single` both high, only samples whose `smp_chan` equals `wd_chan` are checked; samples on other channels have no effect on `viol_flag`.
- R8: Once set, `viol_flag` stays set until a cycle in which `flag_clr` is 1; that cycle clears it on the next edge.
- R9: If `flag_clr` is 1 in the same cycle as a qualified violating sample, `viol_flag` stays set.
- R10: `viol_irq` is 1 exactly when `viol_flag` is 1 and `irq_enable` is 1; it follows `irq_enable` without delay.
- R11: A cycle with `smp_valid` low does not set `viol_flag`, whatever `smp_data` holds.
- R12: A change of `lim_high` or `lim_low` applies to the next sample presented after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Strobe marking a new converted sample |
| smp_data | input | DATA_W | Raw converted value, before alignment |
| smp_chan | input | CHAN_W | Channel index of the sample |
| wd_enable | input | 1 | Turns the window check on |
| wd_single | input | 1 | 1: check only `wd_chan`; 0: check all channels |
| wd_chan | input | CHAN_W | Channel watched in single-channel mode |
| lim_high | input | DATA_W | Upper window limit (inclusive inside) |
| lim_low | input | DATA_W | Lower window limit (inclusive inside) |
| flag_clr | input | 1 | Write-one strobe that clears the flag |
| irq_enable | input | 1 | Routes the flag to the interrupt |
| viol_flag | output | 1 | Sticky out-of-window flag |
| viol_irq | output | 1 | Interrupt request |

## Verification
The only state is the sticky flag, so an internal fault shows at `viol_flag` one cycle after the sample or clear that should have moved it, and at `viol_irq` in the same cycle as the flag. A flag that sets on an in-window sample, on an unwatched channel or with the check off shows as a spurious 1 one cycle later. A flag that drops on its own shows as a 0 while no clear was given. The checks therefore sample the flag one cycle after each stimulus. They also sample it again after idle cycles to confirm that it holds.

// File: rtl/adc_ww_pkg.sv
// Package: shared scope encoding for the window watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_ww_pkg;

    typedef enum logic [1:0] {
        SCOPE_OFF = 2'd0,
        SCOPE_ALL = 2'd1,
        SCOPE_ONE = 2'd2
    } ww_scope_e;

endpackage

// File: rtl/ww_scope_qual.sv
// Module: decides whether the present sample falls under the watch scope.
// Assumes: smp_chan and wd_chan use the same channel numbering.
module ww_scope_qual
    import adc_ww_pkg::*;
#(
    parameter int CHAN_N = 19,
    localparam int CHAN_W = (CHAN_N > 1) ? $clog2(CHAN_N) : 1
) (
    input  logic              smp_valid,
    input  logic [CHAN_W-1:0] smp_chan,
    input  logic              wd_enable,
    input  logic              wd_single,
    input  logic [CHAN_W-1:0] wd_chan,
    output logic              qualified
);

    ww_scope_e scope;
    logic      chan_hit;

    // Decode the enable and single bits into a scope.
    always_comb begin
        if (!wd_enable)     scope = SCOPE_OFF;
        else if (wd_single) scope = SCOPE_ONE;
        else                scope = SCOPE_ALL;
    end

    // Channel match; a single-channel build always matches.
    generate
        if (CHAN_N > 1) begin : g_multi
            assign chan_hit = (smp_chan == wd_chan);
        end else begin : g_single
            assign chan_hit = 1'b1;
        end
    endgenerate

    // Combine strobe, scope and channel match.
    always_comb begin
        unique case (scope)
            SCOPE_ALL: qualified = smp_valid;
            SCOPE_ONE: qualified = smp_valid && chan_hit;
            default:   qualified = 1'b0;
        endcase
    end

endmodule

// File: rtl/ww_window_cmp.sv
// Module: strict out-of-window test on the raw sample.
// Assumes: limits are unsigned; values equal to a limit count as inside.
module ww_window_cmp #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] smp_data,
    input  logic [DATA_W-1:0] lim_high,
    input  logic [DATA_W-1:0] lim_low,
    output logic              outside
);

    // Above the upper limit or below the lower limit.
    always_comb begin
        outside = (smp_data > lim_high) || (smp_data < lim_low);
    end

endmodule

// File: rtl/ww_sticky_flag.sv
// Module: sticky flag with write-one clear; a new hit wins over the clear.
// Assumes: synchronous active-low reset.
module ww_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag
);

    // Hold, set on hit, clear on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

endmodule

// File: rtl/adc_window_watch.sv
// Module: top of the window watchdog comparator.
// Purpose: flags qualified raw samples that lie outside [lim_low, lim_high].
// Assumes: samples arrive as single-cycle strobes; limits may change any time.
module adc_window_watch #(
    parameter int DATA_W = 12,
    parameter int CHAN_N = 19,
    localparam int CHAN_W = (CHAN_N > 1) ? $clog2(CHAN_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [CHAN_W-1:0] smp_chan,
    input  logic              wd_enable,
    input  logic              wd_single,
    input  logic [CHAN_W-1:0] wd_chan,
    input  logic [DATA_W-1:0] lim_high,
    input  logic [DATA_W-1:0] lim_low,
    input  logic              flag_clr,
    input  logic              irq_enable,
    output logic              viol_flag,
    output logic              viol_irq
);

    logic qualified;
    logic outside;
    logic hit;

    ww_scope_qual #(.CHAN_N(CHAN_N)) u_qual (
        .smp_valid (smp_valid),
        .smp_chan  (smp_chan),
        .wd_enable (wd_enable),
        .wd_single (wd_single),
        .wd_chan   (wd_chan),
        .qualified (qualified)
    );

    ww_window_cmp #(.DATA_W(DATA_W)) u_cmp (
        .smp_data (smp_data),
        .lim_high (lim_high),
        .lim_low  (lim_low),
        .outside  (outside)
    );

    // A violation needs both a qualified sample and an outside value.
    assign hit = qualified && outside;

    ww_sticky_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .clr   (flag_clr),
        .flag  (viol_flag)
    );

    // Gate the flag onto the interrupt line.
    assign viol_irq = viol_flag && irq_enable;

endmodule

// File: rtl/ww_checker.sv
// Module: port-level properties of the window watchdog, bound to the top.
// Assumes: synchronous active-low reset; all checks disabled during reset.
module ww_checker #(
    parameter int DATA_W = 12,
    parameter int CHAN_N = 19,
    localparam int CHAN_W = (CHAN_N > 1) ? $clog2(CHAN_N) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [DATA_W-1:0] smp_data,
    input logic [CHAN_W-1:0] smp_chan,
    input logic              wd_enable,
    input logic              wd_single,
    input logic [CHAN_W-1:0] wd_chan,
    input logic [DATA_W-1:0] lim_high,
    input logic [DATA_W-1:0] lim_low,
    input logic              flag_clr,
    input logic              irq_enable,
    input logic              viol_flag,
    input logic              viol_irq
);

    logic in_scope;
    assign in_scope = smp_valid && wd_enable && (!wd_single || smp_chan == wd_chan);

    assert_high_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_scope && smp_data > lim_high) |=> viol_flag);

    assert_low_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_scope && smp_data < lim_low) |=> viol_flag);

    assert_off_no_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!viol_flag && !wd_enable) |=> !viol_flag);

    assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && !flag_clr) |=> viol_flag);

    assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !smp_valid) |=> !viol_flag);

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        viol_irq |-> (viol_flag && irq_enable));

    assert_idle_no_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!viol_flag && !smp_valid) |=> !viol_flag);

endmodule

bind adc_window_watch ww_checker #(.DATA_W(DATA_W), .CHAN_N(CHAN_N)) u_ww_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .smp_data   (smp_data),
    .smp_chan   (smp_chan),
    .wd_enable  (wd_enable),
    .wd_single  (wd_single),
    .wd_chan    (wd_chan),
    .lim_high   (lim_high),
    .lim_low    (lim_low),
    .flag_clr   (flag_clr),
    .irq_enable (irq_enable),
    .viol_flag  (viol_flag),
    .viol_irq   (viol_irq)
);

// File: tb/adc_window_watch_tb.sv
// Bench: directed tests, one task per scenario, each checking its results.
module adc_window_watch_tb;

    localparam int DATA_W = 12;
    localparam int CHAN_N = 19;
    localparam int CHAN_W = $clog2(CHAN_N);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [DATA_W-1:0] smp_data = '0;
    logic [CHAN_W-1:0] smp_chan = '0;
    logic              wd_enable = 1'b0;
    logic              wd_single = 1'b0;
    logic [CHAN_W-1:0] wd_chan = '0;
    logic [DATA_W-1:0] lim_high = 12'hE00;
    logic [DATA_W-1:0] lim_low = 12'h200;
    logic              flag_clr = 1'b0;
    logic              irq_enable = 1'b0;
    logic              viol_flag;
    logic              viol_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adc_window_watch #(.DATA_W(DATA_W), .CHAN_N(CHAN_N)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_chan(smp_chan), .wd_enable(wd_enable), .wd_single(wd_single),
        .wd_chan(wd_chan), .lim_high(lim_high), .lim_low(lim_low),
        .flag_clr(flag_clr), .irq_enable(irq_enable),
        .viol_flag(viol_flag), .viol_irq(viol_irq)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Present one sample for one cycle; outputs settle by the next negedge.
    task automatic send(input logic [DATA_W-1:0] d, input logic [CHAN_W-1:0] c);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = d; smp_chan = c;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(viol_flag, 1'b0, "R1 flag");
        check(viol_irq, 1'b0, "R1 irq");
        rst_n = 1'b1;
    endtask

    task automatic t_high();
        wd_enable = 1'b1; wd_single = 1'b0;
        send(12'hE01, 5'd3);
        check(viol_flag, 1'b1, "R2 above high");
        clear_flag();
        send(12'hFFF, 5'd0);
        check(viol_flag, 1'b1, "R2 max value");
        clear_flag();
    endtask

    task automatic t_low();
        send(12'h1FF, 5'd4);
        check(viol_flag, 1'b1, "R3 below low");
        clear_flag();
        send(12'h000, 5'd4);
        check(viol_flag, 1'b1, "R3 zero");
        clear_flag();
    endtask

    task automatic t_equal();
        send(12'hE00, 5'd1);
        check(viol_flag, 1'b0, "R4 equal high");
        send(12'h200, 5'd1);
        check(viol_flag, 1'b0, "R4 equal low");
        send(12'h800, 5'd1);
        check(viol_flag, 1'b0, "R4 inside");
    endtask

    task automatic t_disabled();
        wd_enable = 1'b0;
        send(12'hFFF, 5'd2);
        check(viol_flag, 1'b0, "R5 disabled high");
        send(12'h000, 5'd2);
        check(viol_flag, 1'b0, "R5 disabled low");
        wd_enable = 1'b1;
    endtask

    task automatic t_all_chan();
        wd_single = 1'b0; wd_chan = 5'd5;
        send(12'hF00, 5'd18);
        check(viol_flag, 1'b1, "R6 any channel");
        clear_flag();
    endtask

    task automatic t_single_chan();
        wd_single = 1'b1; wd_chan = 5'd5;
        send(12'hF00, 5'd6);
        check(viol_flag, 1'b0, "R7 other channel ignored");
        send(12'h100, 5'd4);
        check(viol_flag, 1'b0, "R7 other channel low ignored");
        send(12'hF00, 5'd5);
        check(viol_flag, 1'b1, "R7 watched channel");
        clear_flag();
        wd_single = 1'b0;
    endtask

    task automatic t_sticky();
        send(12'hF00, 5'd0);
        send(12'h800, 5'd0);
        repeat (5) @(negedge clk);
        check(viol_flag, 1'b1, "R8 holds");
        clear_flag();
        check(viol_flag, 1'b0, "R8 cleared");
    endtask

    task automatic t_clear_priority();
        send(12'hF00, 5'd0);
        @(negedge clk);
        flag_clr = 1'b1; smp_valid = 1'b1; smp_data = 12'h050; smp_chan = 5'd0;
        @(negedge clk);
        flag_clr = 1'b0; smp_valid = 1'b0;
        check(viol_flag, 1'b1, "R9 hit beats clear");
        clear_flag();
        check(viol_flag, 1'b0, "R9 later clear");
    endtask

    task automatic t_irq();
        irq_enable = 1'b0;
        send(12'hF00, 5'd0);
        check(viol_irq, 1'b0, "R10 gated off");
        irq_enable = 1'b1;
        #1;
        check(viol_irq, 1'b1, "R10 gated on");
        clear_flag();
        check(viol_irq, 1'b0, "R10 follows clear");
        irq_enable = 1'b0;
    endtask

    task automatic t_valid_low();
        @(negedge clk);
        smp_data = 12'hFFF; smp_valid = 1'b0;
        @(negedge clk);
        check(viol_flag, 1'b0, "R11 no strobe");
        smp_data = '0;
    endtask

    task automatic t_lim_change();
        lim_high = 12'h900;
        send(12'hA00, 5'd0);
        check(viol_flag, 1'b1, "R12 new high");
        clear_flag();
        lim_high = 12'hFFF; lim_low = 12'h000;
        send(12'h000, 5'd0);
        check(viol_flag, 1'b0, "R12 widened window");
        lim_low = 12'h400;
        send(12'h300, 5'd0);
        check(viol_flag, 1'b1, "R12 raised low");
        clear_flag();
    endtask

    initial begin
        t_reset();
        t_high();
        t_low();
        t_equal();
        t_disabled();
        t_all_chan();
        t_single_chan();
        t_sticky();
        t_clear_priority();
        t_irq();
        t_valid_low();
        t_lim_change();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule